// File: doc/BRIEF.md
# Bit-Masked Two-Port Block Memory

This block is a 256-word by 16-bit memory with one write port and one read port that run from separate clocks. Each port has its own enable and its own address. A write updates the addressed word one bit at a time: every data bit travels with a mask bit, and only the unmasked bits are stored. The read port places the addressed word in an output register. That register keeps its value whenever no read is issued.

The memory starts with contents taken from a parameter image, which holds all zeros unless the integrator supplies one. A parameter selects the active clock edge of each port, rising or falling. An active-low reset, sampled by each port on its own active edge, blocks writes and reads while it is low. The reset clears neither the stored words nor the output register. Integrators use the block for line buffers, lookup tables, register files and similar storage, and put any wider or deeper arrangement outside it.

Top module: `bitmask_dpram`

## Requirements
- R1: The memory holds 256 words of 16 bits. After a write, a read of that address returns the stored word, at both the lowest (0x00) and highest (0xFF) address.
- R2: Memory changes only on an active write-clock edge with `wr_en` = 1 and `rst_n` = 1. When `wr_en` = 0, the addressed word keeps its contents.
- R3: In a write, for each bit i, `wr_mask[i]` = 0 stores `wr_data[i]` and `wr_mask[i]` = 1 keeps the stored bit i.
- R4: On an active read-clock edge with `rd_en` = 1 and `rst_n` = 1, `rd_data` takes the word at `rd_addr`. The new value is visible right after that edge.
- R5: When `rd_en` = 0, `rd_data` keeps its previous value.
- R6: While `rst_n` is 0, reads and writes are suppressed. `rd_data` is not cleared and memory contents are kept.
- R7: When the same edge writes and reads the same address, the read returns the contents from before the write.
- R8: At start-up, word k holds `INIT_IMAGE[k*16 +: 16]`.
- R9: With `WR_EDGE`/`RD_EDGE` set to `EDGE_FALL`, the port acts on the falling edge of its clock and does nothing on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset, sampled by each port on its active edge; blocks operations only |
| wr_clk | input | 1 | Write-port clock |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 16 | Write data |
| wr_mask | input | 16 | Per-bit write mask, 1 keeps the stored bit |
| rd_clk | input | 1 | Read-port clock |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read word address |
| rd_data | output | 16 | Registered read word |

## Verification
The bench writes words with mask patterns that alternate bit by bit and half by half. A design that masked whole bytes, or reversed the sense of the mask, would return the wrong merged words. It reads and writes one address on the same edge, where a write-first design would return the new word instead of the old one. It holds reset while write and read requests are active. A design that cleared the output register, or let the write through, would show zero or the overwritten word. A second instance set to falling edges is sampled just after each edge, so a design that ignored the edge parameter would update half a cycle late.

// File: rtl/bitmask_dpram_pkg.sv
// Shared types for the bit-masked two-port memory.
package bitmask_dpram_pkg;
    // Active clock edge of a memory port.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } clk_edge_e;
endpackage

// File: rtl/bitmask_dpram_merge.sv
// Combinational per-bit merge of write data into the current word.
// Assumes: a mask bit of 1 keeps the old bit, 0 takes the new bit.
module bitmask_dpram_merge #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_data,
    input  logic [DATA_W-1:0] keep_mask,
    output logic [DATA_W-1:0] merged
);
    // One selector per bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign merged[b] = keep_mask[b] ? old_word[b] : new_data[b];
    end
endmodule

// File: rtl/bitmask_dpram_store.sv
// Word array with a clocked write on a selectable edge and an unclocked
// look-up for the read register. Contents start from INIT_IMAGE.
// Assumes: wr_word is already merged; wr_go folds enable and reset.
module bitmask_dpram_store
    import bitmask_dpram_pkg::*;
#(
    parameter int        ADDR_W  = 8,
    parameter int        DATA_W  = 16,
    parameter clk_edge_e WR_EDGE = EDGE_RISE,
    parameter logic [DATA_W*(2**ADDR_W)-1:0] INIT_IMAGE = '0
) (
    input  logic              wr_clk,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] wr_look_addr,
    output logic [DATA_W-1:0] wr_look_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Preload every word from the parameter image.
    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            mem[k] = INIT_IMAGE[k*DATA_W +: DATA_W];
        end
    end

    // Unclocked look-ups for the merge and the read register.
    assign wr_look_word = mem[wr_look_addr];
    assign rd_word      = mem[rd_addr];

    if (WR_EDGE == EDGE_FALL) begin : g_wr_fall
        // Store the merged word on the falling edge.
        always_ff @(negedge wr_clk) begin
            if (wr_go) mem[wr_addr] <= wr_word;
        end
    end else begin : g_wr_rise
        // Store the merged word on the rising edge.
        always_ff @(posedge wr_clk) begin
            if (wr_go) mem[wr_addr] <= wr_word;
        end
    end
endmodule

// File: rtl/bitmask_dpram_rdreg.sv
// Read output register on a selectable edge. It has no clear: it loads
// only on a permitted read and otherwise holds.
module bitmask_dpram_rdreg
    import bitmask_dpram_pkg::*;
#(
    parameter int        DATA_W  = 16,
    parameter clk_edge_e RD_EDGE = EDGE_RISE
) (
    input  logic              rd_clk,
    input  logic              rd_go,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_q
);
    if (RD_EDGE == EDGE_FALL) begin : g_rd_fall
        // Capture the looked-up word on the falling edge.
        always_ff @(negedge rd_clk) begin
            if (rd_go) rd_q <= rd_word;
        end
    end else begin : g_rd_rise
        // Capture the looked-up word on the rising edge.
        always_ff @(posedge rd_clk) begin
            if (rd_go) rd_q <= rd_word;
        end
    end
endmodule

// File: rtl/bitmask_dpram.sv
// Bit-masked two-port memory: one write port with per-bit mask and one
// registered read port, each on its own clock and selectable edge.
// Assumes: rst_n meets setup to both clocks; it blocks operations only.
module bitmask_dpram
    import bitmask_dpram_pkg::*;
#(
    parameter int        ADDR_W  = 8,
    parameter int        DATA_W  = 16,
    parameter clk_edge_e WR_EDGE = EDGE_RISE,
    parameter clk_edge_e RD_EDGE = EDGE_RISE,
    parameter logic [DATA_W*(2**ADDR_W)-1:0] INIT_IMAGE = '0
) (
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] merged_word;
    logic [DATA_W-1:0] look_word;
    logic              wr_go;
    logic              rd_go;

    // Operations are permitted only outside reset.
    assign wr_go = wr_en & rst_n;
    assign rd_go = rd_en & rst_n;

    bitmask_dpram_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .old_word  (cur_word),
        .new_data  (wr_data),
        .keep_mask (wr_mask),
        .merged    (merged_word)
    );

    bitmask_dpram_store #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .WR_EDGE    (WR_EDGE),
        .INIT_IMAGE (INIT_IMAGE)
    ) u_store (
        .wr_clk       (wr_clk),
        .wr_go        (wr_go),
        .wr_addr      (wr_addr),
        .wr_word      (merged_word),
        .wr_look_addr (wr_addr),
        .wr_look_word (cur_word),
        .rd_addr      (rd_addr),
        .rd_word      (look_word)
    );

    bitmask_dpram_rdreg #(
        .DATA_W  (DATA_W),
        .RD_EDGE (RD_EDGE)
    ) u_rdreg (
        .rd_clk  (rd_clk),
        .rd_go   (rd_go),
        .rd_word (look_word),
        .rd_q    (rd_data)
    );
endmodule

// File: rtl/bitmask_dpram_chk.sv
// Checker for bitmask_dpram. Keeps its own image of the memory and
// checks the read register against it. Active only when both ports use
// rising edges; assumes both ports then share one clock.
module bitmask_dpram_chk
    import bitmask_dpram_pkg::*;
#(
    parameter int        ADDR_W  = 8,
    parameter int        DATA_W  = 16,
    parameter clk_edge_e WR_EDGE = EDGE_RISE,
    parameter clk_edge_e RD_EDGE = EDGE_RISE,
    parameter logic [DATA_W*(2**ADDR_W)-1:0] INIT_IMAGE = '0
) (
    input logic              rst_n,
    input logic              wr_clk,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] wr_mask,
    input logic              rd_clk,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 2 ** ADDR_W;

    if (WR_EDGE == EDGE_RISE && RD_EDGE == EDGE_RISE) begin : g_on
        logic [DATA_W-1:0] shadow [DEPTH];
        logic [DATA_W-1:0] exp_word;
        logic              read_seen = 1'b0;

        // Load the checker image from the same parameter.
        initial begin
            for (int k = 0; k < DEPTH; k++) begin
                shadow[k] = INIT_IMAGE[k*DATA_W +: DATA_W];
            end
        end

        // Follow permitted writes bit by bit.
        always_ff @(posedge wr_clk) begin
            if (rst_n && wr_en) begin
                for (int b = 0; b < DATA_W; b++) begin
                    if (!wr_mask[b]) shadow[wr_addr][b] <= wr_data[b];
                end
            end
        end

        // Note once the read register has been loaded.
        always_ff @(posedge rd_clk) begin
            if (rst_n && rd_en) read_seen <= 1'b1;
        end

        assign exp_word = shadow[rd_addr];

        AST_RD_LOADS: assert property (@(posedge rd_clk) disable iff (!rst_n)
            rd_en |=> rd_data == $past(exp_word)); // R4
        AST_RD_HOLDS: assert property (@(posedge rd_clk) disable iff (!rst_n)
            (read_seen && !rd_en) |=> $stable(rd_data)); // R5
        AST_COLLIDE_OLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
            (rd_en && wr_en && rd_addr == wr_addr) |=> rd_data == $past(exp_word)); // R7
        AST_RD_DEFINED: assert property (@(posedge rd_clk) disable iff (!rst_n)
            rd_en |=> !$isunknown(rd_data)); // R8
        AST_WR_CTRL_KNOWN: assert property (@(posedge wr_clk) disable iff (!rst_n)
            wr_en |-> !$isunknown({wr_addr, wr_mask})); // R2
    end
endmodule

bind bitmask_dpram bitmask_dpram_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .WR_EDGE    (WR_EDGE),
    .RD_EDGE    (RD_EDGE),
    .INIT_IMAGE (INIT_IMAGE)
) u_chk (
    .rst_n   (rst_n),
    .wr_clk  (wr_clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .rd_clk  (rd_clk),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/bitmask_dpram_bench.sv
// Bench for bitmask_dpram: vector table on a rising-edge instance, then
// directed reset and falling-edge tests.
module bitmask_dpram_bench;
    import bitmask_dpram_pkg::*;

    // Word k of the start image is {k ^ 8'h5A, k}.
    function automatic logic [4095:0] make_image();
        logic [4095:0] img;
        for (int k = 0; k < 256; k++) begin
            img[k*16 +: 16] = {8'(k) ^ 8'h5A, 8'(k)};
        end
        return img;
    endfunction
    localparam logic [4095:0] IMG = make_image();

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, wr_mask = '0;
    logic [15:0] rd_data;

    logic        n_wr_en = 1'b0, n_rd_en = 1'b0;
    logic [7:0]  n_wr_addr = '0, n_rd_addr = '0;
    logic [15:0] n_wr_data = '0, n_wr_mask = '0;
    logic [15:0] n_rd_data;

    int tests = 0;
    int fails = 0;

    bitmask_dpram #(.INIT_IMAGE(IMG)) u_bitmask_dpram (
        .rst_n(rst_n), .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_clk(clk), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data));

    bitmask_dpram #(.WR_EDGE(EDGE_FALL), .RD_EDGE(EDGE_FALL), .INIT_IMAGE(IMG))
    u_bitmask_dpram_fall (
        .rst_n(rst_n), .wr_clk(clk), .wr_en(n_wr_en), .wr_addr(n_wr_addr),
        .wr_data(n_wr_data), .wr_mask(n_wr_mask), .rd_clk(clk), .rd_en(n_rd_en),
        .rd_addr(n_rd_addr), .rd_data(n_rd_data));

    // Row: {wr_en, wr_addr, wr_data, wr_mask, rd_en, rd_addr, expected}.
    localparam int NV = 13;
    localparam logic [65:0] VEC [NV] = '{
        {1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1, 8'h10, 16'h4A10},
        {1'b1, 8'h10, 16'h1234, 16'h0000, 1'b1, 8'h10, 16'h4A10},
        {1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1, 8'h10, 16'h1234},
        {1'b1, 8'h10, 16'hFFFF, 16'hFF00, 1'b0, 8'h10, 16'h1234},
        {1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1, 8'h10, 16'h12FF},
        {1'b1, 8'h20, 16'h0000, 16'hAAAA, 1'b1, 8'hFF, 16'hA5FF},
        {1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1, 8'h20, 16'h2A20},
        {1'b0, 8'h20, 16'hFFFF, 16'h0000, 1'b1, 8'h20, 16'h2A20},
        {1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1, 8'h20, 16'h2A20},
        {1'b1, 8'hFF, 16'h0F0F, 16'h0000, 1'b1, 8'h00, 16'h5A00},
        {1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1, 8'hFF, 16'h0F0F},
        {1'b1, 8'hFF, 16'hF0F0, 16'h00FF, 1'b1, 8'hFF, 16'h0F0F},
        {1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1, 8'hFF, 16'hF00F}
    };
    localparam string VREQ [NV] = '{"R8", "R7", "R1", "R5", "R3", "R4", "R3",
                                     "R2", "R2", "R4", "R1", "R7", "R3"};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One rising-edge cycle: inputs are already set; return at the next falling edge.
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One falling-edge step for the second instance: return 2 ns after it.
    task automatic fall_step();
        @(negedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            {wr_en, wr_addr, wr_data, wr_mask, rd_en, rd_addr} = VEC[i][65:16];
            cycle();
            check(VREQ[i], rd_data, VEC[i][15:0]);
        end

        // R6: reset blocks the write and the read; the register is kept.
        rst_n = 1'b0;
        wr_en = 1'b1; wr_addr = 8'h10; wr_data = 16'h0000; wr_mask = 16'h0000;
        rd_en = 1'b1; rd_addr = 8'h20;
        cycle();
        cycle();
        check("R6", rd_data, 16'hF00F);
        rst_n = 1'b1;
        wr_en = 1'b0; rd_addr = 8'h10;
        cycle();
        check("R6", rd_data, 16'h12FF);
        rd_en = 1'b0;

        // R9: falling-edge instance, inputs set just after a rising edge.
        @(posedge clk);
        #2;
        n_wr_en = 1'b1; n_wr_addr = 8'h05; n_wr_data = 16'hBEEF; n_wr_mask = 16'h0000;
        n_rd_en = 1'b1; n_rd_addr = 8'h05;
        fall_step();
        check("R9", n_rd_data, 16'h5F05);
        n_wr_en = 1'b0;
        fall_step();
        check("R9", n_rd_data, 16'hBEEF);
        n_rd_en = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule